// File: doc/BRIEF.md
# Serial Page-Buffered Flash Command Controller

This block sits on the host side of a four-wire SPI link to a serial flash organised as 512 pages of 264 bytes, with a single 264-byte SRAM staging buffer in the device. A local requester asks for one of four operations through a request/acknowledge handshake: fill the device buffer, commit the buffer into a main-memory page, read the buffer back, or stream main memory continuously from a given page and byte. For each request the controller drops chip select, shifts out an opcode byte, three address bytes and any filler bytes, and then moves data in or out. When the frame is complete it raises chip select again and pulses a done strobe.

Page and byte offset are packed into the address as page number above a 9-bit byte field, because the 264-byte page is not a power of two. A ready/busy input from the device goes through a synchroniser and gates the page-commit and array-read operations. Buffer fills and buffer reads may run while the device is still busy with an earlier commit. The serial clock is the system clock divided by a parameter. A configuration input selects the idle clock level, which gives mode 0 or mode 3. An offset that points outside a page is refused with an error and no frame is sent.

Top module: `spf_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, cs_no is high, sck_o equals cpol_i, and ack_o, done_o, err_o, wr_strb_o and rd_vld_o are low.
- R2: ack_o is a one-cycle pulse in a cycle where the controller is idle and req_i is high. Every accepted request ends with exactly one one-cycle done_o pulse, and a legal request produces exactly one chip-select frame.
- R3: cs_no stays low for the whole frame. The first byte is the opcode: op_i 0 (buffer fill) sends 0x84, 1 (page commit) sends 0x83, 2 (buffer read) sends 0xD4 and 3 (continuous array read) sends 0xE8.
- R4: Three address bytes follow the opcode, most significant first. Ops 1 and 3 send page_i*512 + offset_i (page in address bits 17:9, offset in bits 8:0). Ops 0 and 2 send offset_i alone. All other bits are zero.
- R5: Every byte is shifted most significant bit first. mosi_o changes only while sck_o is low and is stable across each rising edge of sck_o inside a frame.
- R6: While cs_no is high, sck_o rests at the cpol_i level and shows no edges.
- R7: Inside a frame, each sck_o level lasts at least HALF_DIV system clock cycles.
- R8: Ops 1 and 3 do not lower cs_no until rdy_i has been seen high through the synchroniser.
- R9: Ops 0 and 2 start their frame whether or not rdy_i is high.
- R10: Op 0 sends len_i data bytes after the address. wr_strb_o pulses once per byte, and the value on wdata_i in a strobe cycle is the byte sent next.
- R11: Reads send 0x00 on mosi_o after the address. The first 4 received bytes (op 3) or the first 1 (op 2) are discarded. The next len_i bytes are returned in order on rdata_o, each with a rd_vld_o pulse, and an op 3 frame streams across page boundaries without a new frame.
- R12: An offset_i of 264 or more completes with done_o and err_o together, and cs_no stays high.
- R13: An op 1 frame is exactly four bytes long and carries no data, whatever len_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpol_i | input | 1 | Idle level of the serial clock (0: mode 0, 1: mode 3) |
| req_i | input | 1 | Request valid |
| op_i | input | 2 | Operation: 0 fill, 1 commit, 2 buffer read, 3 array read |
| page_i | input | 9 | Main-memory page number |
| offset_i | input | 9 | Byte offset inside page or buffer |
| len_i | input | 12 | Number of data bytes to move |
| ack_o | output | 1 | Request accepted |
| done_o | output | 1 | Request finished |
| err_o | output | 1 | Request refused (with done_o) |
| wdata_i | input | 8 | Fill data byte |
| wr_strb_o | output | 1 | Fill byte taken |
| rdata_o | output | 8 | Received data byte |
| rd_vld_o | output | 1 | rdata_o valid |
| rdy_i | input | 1 | Device ready (high) / busy (low) |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to device |
| miso_i | input | 1 | Serial data from device |

## Verification
A wrong byte index or a bad header length shows on the link within the frame concerned: an opcode, address or filler byte lands in the wrong slot, and the bench's byte-by-byte comparison catches it at the eighth rising clock edge of that byte. A wrong dummy count moves the returned data by whole bytes, so the first rd_vld_o pulse already carries the wrong value. A busy gate that is stuck open lowers chip select during the hold window, and a stuck offset check either sends a frame it should refuse or withholds err_o at the done pulse. A divider error is caught at the first short clock level.

// File: rtl/spf_pkg.sv
`timescale 1ns/1ps
package spf_pkg;
  typedef enum logic [1:0] {
    OP_BUF_WR = 2'd0,
    OP_PROG   = 2'd1,
    OP_BUF_RD = 2'd2,
    OP_MEM_RD = 2'd3
  } spf_op_e;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER, S_END} spf_state_e;

  localparam int unsigned ADDR_BYTES   = 3;
  localparam int unsigned MEM_RD_DUMMY = 4;
  localparam int unsigned BUF_RD_DUMMY = 1;

  function automatic logic [7:0] opcode_of(spf_op_e op);
    case (op)
      OP_BUF_WR: return 8'h84;
      OP_PROG:   return 8'h83;
      OP_BUF_RD: return 8'hD4;
      default:   return 8'hE8;
    endcase
  endfunction

  function automatic logic needs_ready(spf_op_e op);
    return (op == OP_PROG) || (op == OP_MEM_RD);
  endfunction
endpackage

// File: rtl/spf_sync.sv
`timescale 1ns/1ps
module spf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  // reset to 0 = busy, the safe assumption
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/spf_shift.sv
`timescale 1ns/1ps
module spf_shift #(
  parameter int HALF_DIV = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hold_i,
  input  logic       idle_lvl_i,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic          busy_q, high_q, sck_q, done_q;
  logic [7:0]    tx_q, rx_q;
  logic          tick;

  assign tick = (cnt_q == CW'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; bit_q <= '0; busy_q <= 1'b0; high_q <= 1'b0;
      sck_q <= 1'b0; done_q <= 1'b0; tx_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (hold_i) begin
        sck_q  <= idle_lvl_i;
        busy_q <= 1'b0;
      end else if (start_i) begin
        busy_q <= 1'b1; high_q <= 1'b0; sck_q <= 1'b0;
        cnt_q  <= '0;   bit_q  <= '0;   tx_q  <= tx_i;
      end else if (busy_q) begin
        if (!tick) cnt_q <= cnt_q + CW'(1);
        else begin
          cnt_q <= '0;
          if (!high_q) begin
            high_q <= 1'b1; sck_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else if (bit_q == 3'd7) begin
            busy_q <= 1'b0; done_q <= 1'b1;  // clock parks high between bytes
          end else begin
            bit_q  <= bit_q + 3'd1; high_q <= 1'b0; sck_q <= 1'b0;
            tx_q   <= {tx_q[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = tx_q[7];
  assign rx_o   = rx_q;
  assign done_o = done_q;
endmodule

// File: rtl/spf_frame.sv
`timescale 1ns/1ps
module spf_frame
  import spf_pkg::*;
#(
  parameter int PAGE_W = 9,
  parameter int OFS_W  = 9,
  parameter int LEN_W  = 12,
  parameter int IDX_W  = 13
) (
  input  spf_op_e          op_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        tx_o,
  output logic              data_o,
  output logic              last_o
);
  localparam int AW = 8 * ADDR_BYTES;

  logic [AW-1:0]    addr, addr_sh;
  logic [IDX_W-1:0] hdr, dlen;
  logic [IDX_W+2:0] sh;

  always_comb begin
    if (needs_ready(op_i)) addr = AW'({page_i, ofs_i});
    else                   addr = AW'(ofs_i);
    hdr = IDX_W'(1 + ADDR_BYTES);
    if (op_i == OP_MEM_RD)      hdr = hdr + IDX_W'(MEM_RD_DUMMY);
    else if (op_i == OP_BUF_RD) hdr = hdr + IDX_W'(BUF_RD_DUMMY);
    dlen   = (op_i == OP_PROG) ? '0 : IDX_W'(len_i);
    data_o = (idx_i >= hdr);
    last_o = (idx_i == hdr + dlen - IDX_W'(1));
    sh      = {IDX_W'(ADDR_BYTES) - idx_i, 3'b000};
    addr_sh = addr >> sh;
    tx_o    = 8'h00;
    if (idx_i == '0)                          tx_o = opcode_of(op_i);
    else if (idx_i <= IDX_W'(ADDR_BYTES))     tx_o = addr_sh[7:0];
    else if (data_o && op_i == OP_BUF_WR)     tx_o = wdata_i;
  end
endmodule

// File: rtl/spf_ctrl.sv
`timescale 1ns/1ps
module spf_ctrl
  import spf_pkg::*;
#(
  parameter int PAGES       = 512,
  parameter int PAGE_BYTES  = 264,
  parameter int LEN_W       = 12,
  parameter int HALF_DIV    = 5,
  parameter int SYNC_STAGES = 2,
  localparam int PAGE_W     = $clog2(PAGES),
  localparam int OFS_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpol_i,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              ack_o,
  output logic              done_o,
  output logic              err_o,
  input  logic [7:0]        wdata_i,
  output logic              wr_strb_o,
  output logic [7:0]        rdata_o,
  output logic              rd_vld_o,
  input  logic              rdy_i,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int IDX_W = LEN_W + 1;
  localparam int GUARD = SYNC_STAGES + 1;  // lets busy reach the synchroniser
  localparam int GW    = $clog2(GUARD + 1);

  spf_state_e        state_q;
  spf_op_e           op_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [LEN_W-1:0]  len_q;
  logic [IDX_W-1:0]  idx_q;
  logic [GW-1:0]     gcnt_q;
  logic              go_q, err_q, rd_vld_q;
  logic [7:0]        rdata_q;

  logic       rdy_s, in_frame, sh_sck, sh_done, fr_data, fr_last, is_rd;
  logic [7:0] fr_tx, sh_rx;

  spf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rdy_i), .q_o(rdy_s));

  spf_frame #(.PAGE_W(PAGE_W), .OFS_W(OFS_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_frame (
    .op_i(op_q), .page_i(page_q), .ofs_i(ofs_q), .len_i(len_q), .idx_i(idx_q),
    .wdata_i(wdata_i), .tx_o(fr_tx), .data_o(fr_data), .last_o(fr_last));

  spf_shift #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(!in_frame), .idle_lvl_i(cpol_i),
    .start_i(go_q), .tx_i(fr_tx), .miso_i(miso_i), .sck_o(sh_sck),
    .mosi_o(mosi_o), .rx_o(sh_rx), .done_o(sh_done));

  assign in_frame = (state_q == S_XFER);
  assign is_rd    = (op_q == OP_BUF_RD) || (op_q == OP_MEM_RD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; op_q <= OP_BUF_WR; page_q <= '0; ofs_q <= '0; len_q <= '0;
      idx_q <= '0; gcnt_q <= '0; go_q <= 1'b0; err_q <= 1'b0;
      rd_vld_q <= 1'b0; rdata_q <= '0;
    end else begin
      go_q     <= 1'b0;
      rd_vld_q <= 1'b0;
      case (state_q)
        S_IDLE: if (req_i) begin
          op_q <= spf_op_e'(op_i); page_q <= page_i; ofs_q <= offset_i; len_q <= len_i;
          idx_q <= '0; gcnt_q <= '0; err_q <= 1'b0;
          if (offset_i >= OFS_W'(PAGE_BYTES)) begin
            err_q <= 1'b1; state_q <= S_END;
          end else if (needs_ready(spf_op_e'(op_i))) state_q <= S_WAIT;
          else begin state_q <= S_XFER; go_q <= 1'b1; end
        end
        S_WAIT: if (rdy_s) begin state_q <= S_XFER; go_q <= 1'b1; end
        S_XFER: if (sh_done) begin
          if (fr_data && is_rd) begin rd_vld_q <= 1'b1; rdata_q <= sh_rx; end
          if (fr_last) state_q <= S_END;
          else begin idx_q <= idx_q + IDX_W'(1); go_q <= 1'b1; end
        end
        default: if (gcnt_q == GW'(GUARD - 1)) state_q <= S_IDLE;
                 else gcnt_q <= gcnt_q + GW'(1);
      endcase
    end
  end

  assign ack_o     = (state_q == S_IDLE) && req_i;
  assign done_o    = (state_q == S_END) && (gcnt_q == GW'(GUARD - 1));
  assign err_o     = done_o && err_q;
  assign wr_strb_o = go_q && fr_data && (op_q == OP_BUF_WR);
  assign rdata_o   = rdata_q;
  assign rd_vld_o  = rd_vld_q;
  assign cs_no     = !in_frame;
  assign sck_o     = in_frame ? sh_sck : cpol_i;
endmodule

// File: rtl/spf_ctrl_chk.sv
`timescale 1ns/1ps
module spf_ctrl_chk #(
  parameter int HALF_DIV = 5
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cpol_i,
  input logic ack_o,
  input logic done_o,
  input logic err_o,
  input logic wr_strb_o,
  input logic sck_o,
  input logic cs_no,
  input logic mosi_o
);
  localparam int CW = $clog2(HALF_DIV + 1) + 1;

  logic [CW-1:0] hcnt_q;
  logic          sck_prev_q, cs_prev_q, cpol_prev_q, mosi_prev_q;
  logic          chg;

  assign chg = (sck_o != sck_prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= CW'(HALF_DIV); sck_prev_q <= 1'b0; cs_prev_q <= 1'b1;
      cpol_prev_q <= 1'b0; mosi_prev_q <= 1'b0;
    end else begin
      sck_prev_q  <= sck_o;
      cs_prev_q   <= cs_no;
      cpol_prev_q <= cpol_i;
      mosi_prev_q <= mosi_o;
      if (chg) hcnt_q <= '0;
      else if (hcnt_q < CW'(HALF_DIV)) hcnt_q <= hcnt_q + CW'(1);
    end
  end

  a_r1_reset_cs_high: assert property (@(posedge clk_i) !rst_ni |-> cs_no);

  a_r2_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_mosi_stable_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !cs_prev_q && sck_o && !sck_prev_q) |-> (mosi_o == mosi_prev_q));

  a_r6_idle_no_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no && cs_prev_q && cpol_i == cpol_prev_q) |-> !chg);

  a_r7_half_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && !cs_no && !cs_prev_q) |-> (hcnt_q >= CW'(HALF_DIV - 1)));

  a_r10_strobe_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strb_o |-> !cs_no);

  a_r12_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

bind spf_ctrl spf_ctrl_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpol_i(cpol_i), .ack_o(ack_o), .done_o(done_o),
  .err_o(err_o), .wr_strb_o(wr_strb_o), .sck_o(sck_o), .cs_no(cs_no), .mosi_o(mosi_o));

// File: tb/spf_ctrl_tb_top.sv
`timescale 1ns/1ps
module spf_ctrl_tb_top;
  localparam int HALF = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cpol = 1'b0, req = 1'b0, rdy = 1'b1, miso = 1'b0;
  logic [1:0]  op = '0;
  logic [8:0]  page = '0, ofs = '0;
  logic [11:0] len = '0;
  logic [7:0]  wdata;
  logic        ack, done, err, wr_strb, rd_vld, sck, cs_n, mosi;
  logic [7:0]  rdata;

  spf_ctrl #(.HALF_DIV(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpol_i(cpol), .req_i(req), .op_i(op), .page_i(page),
    .offset_i(ofs), .len_i(len), .ack_o(ack), .done_o(done), .err_o(err),
    .wdata_i(wdata), .wr_strb_o(wr_strb), .rdata_o(rdata), .rd_vld_o(rd_vld),
    .rdy_i(rdy), .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso));

  int n_chk = 0, n_err = 0;
  int frames = 0, fbytes = 0, last_fbytes = 0, nstrb = 0, minh = 1000, hcnt = 1000;
  int widx = 0, bitn = 0, capn = 0;
  bit sampled = 0, psck = 0, pcs = 1, finished = 0;
  logic [7:0] cap = '0;
  logic [7:0] q_v[$];
  string      q_t[$];
  logic [7:0] q_rd[$];

  function automatic logic [7:0] pat(int b);  return 8'(b * 37 + 90); endfunction
  function automatic logic [7:0] wval(int i); return 8'(i * 13 + 3);  endfunction

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req_tag, act, exp);
    end
  endtask

  assign wdata = wval(widx);
  always @(posedge clk) if (wr_strb) widx <= widx + 1;

  // device model and MOSI scoreboard monitor
  always @(negedge clk) begin
    logic [7:0] cur;
    if (cs_n) begin
      if (!pcs) last_fbytes = fbytes;
      bitn = 0; sampled = 0; capn = 0; hcnt = 1000;
    end else begin
      if (pcs) begin frames++; fbytes = 0; end
      if (sck != psck) begin
        if (!pcs && hcnt < minh) minh = hcnt;
        hcnt = 1;
      end else if (hcnt < 1000) hcnt++;
      if (sck && !psck) begin
        sampled = 1; cap = {cap[6:0], mosi}; capn++;
        if (capn == 8) begin
          capn = 0; fbytes++;
          if (q_v.size() == 0) check(0, "R3 unexpected byte", cap, 0);
          else begin
            check(cap == q_v[0], q_t[0], cap, q_v[0]);
            void'(q_v.pop_front()); void'(q_t.pop_front());
          end
        end
      end
      if (!sck && psck && sampled) begin sampled = 0; bitn++; end
    end
    psck = sck; pcs = cs_n;
    cur = pat(bitn / 8);
    miso = cur[7 - (bitn % 8)];
  end

  // read-data scoreboard monitor
  always @(negedge clk) begin
    if (rd_vld) begin
      if (q_rd.size() == 0) check(0, "R11 unexpected rdata", rdata, 0);
      else begin
        check(rdata == q_rd[0], "R11 rdata", rdata, q_rd[0]);
        void'(q_rd.pop_front());
      end
    end
    if (wr_strb) nstrb++;
  end

  int frames0, strb0;

  task automatic push(input logic [7:0] v, input string t);
    q_v.push_back(v); q_t.push_back(t);
  endtask

  task automatic issue_req(input int o, input int pg, input int of, input int ln, input bit bad);
    logic [23:0] a;
    int dm;
    logic [7:0] opc;
    dm  = (o == 3) ? 4 : (o == 2) ? 1 : 0;
    opc = (o == 0) ? 8'h84 : (o == 1) ? 8'h83 : (o == 2) ? 8'hD4 : 8'hE8;
    a   = (o == 1 || o == 3) ? 24'(pg * 512 + of) : 24'(of);
    if (!bad) begin
      push(opc, "R3 opcode");
      push(a[23:16], "R4/R5 addr hi"); push(a[15:8], "R4/R5 addr mid"); push(a[7:0], "R4/R5 addr lo");
      for (int i = 0; i < dm; i++) push(8'h00, "R11 dummy filler");
      if (o == 0) for (int j = 0; j < ln; j++) push(wval(widx + j), "R10 fill data");
      if (o >= 2) for (int j = 0; j < ln; j++) begin
        push(8'h00, "R11 read filler");
        q_rd.push_back(pat(4 + dm + j));
      end
    end
    frames0 = frames; strb0 = nstrb;
    @(negedge clk);
    op = 2'(o); page = 9'(pg); ofs = 9'(of); len = 12'(ln); req = 1'b1;
    #1;
    check(ack == 1'b1, "R2 ack when idle", ack, 1);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic finish_req(input bit bad, input int exp_strb);
    int c = 0;
    while (!done && c < 20000) begin @(negedge clk); c++; end
    check(done == 1'b1, "R2 done pulse", done, 1);
    check(err == bad, "R12 err flag", err, bad);
    check(frames - frames0 == (bad ? 0 : 1), bad ? "R12 no frame" : "R2 one frame", frames - frames0, bad ? 0 : 1);
    check(nstrb - strb0 == exp_strb, "R10 strobe count", nstrb - strb0, exp_strb);
    check(q_v.size() == 0, "R3 all bytes sent", q_v.size(), 0);
    check(q_rd.size() == 0, "R11 all data returned", q_rd.size(), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R1 cs high in reset", cs_n, 1);
    check(sck == cpol, "R1 sck idle in reset", sck, cpol);
    check({ack, done, err, wr_strb, rd_vld} == 5'b0, "R1 strobes low in reset",
          {ack, done, err, wr_strb, rd_vld}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cs_n == 1'b1 && sck == 1'b0, "R1 idle after reset", {cs_n, sck}, 2);

    issue_req(0, 0, 5, 8, 0);  finish_req(0, 8);
    issue_req(1, 300, 0, 7, 0); finish_req(0, 0);
    check(last_fbytes == 4, "R13 commit frame length", last_fbytes, 4);

    rdy = 1'b0;  // device busy after commit
    issue_req(0, 0, 263, 3, 0); finish_req(0, 3);
    check(frames == frames0 + 1, "R9 fill runs while busy", frames - frames0, 1);
    issue_req(2, 0, 10, 6, 0); finish_req(0, 0);
    check(frames == frames0 + 1, "R9 buffer read runs while busy", frames - frames0, 1);

    issue_req(3, 3, 260, 10, 0);
    repeat (300) @(negedge clk);
    check(cs_n == 1'b1 && frames == frames0, "R8 held off while busy", frames - frames0, 0);
    rdy = 1'b1;
    finish_req(0, 0);
    check(last_fbytes == 18, "R11 page crossing in one frame", last_fbytes, 18);

    issue_req(0, 0, 264, 4, 1); finish_req(1, 0);
    issue_req(3, 7, 511, 4, 1); finish_req(1, 0);

    cpol = 1'b1;
    repeat (4) @(negedge clk);
    check(sck == 1'b1, "R6 idle level mode 3", sck, 1);
    issue_req(3, 511, 0, 4, 0); finish_req(0, 0);
    repeat (2) @(negedge clk);
    check(sck == 1'b1, "R6 idle level after frame", sck, 1);

    check(minh >= HALF, "R7 minimum half period", minh, HALF);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule